// File: doc/BRIEF.md
# Programmable Clock Divider with Delayed Companion Output

The block turns a fast input clock into a slower one. In this code base the fast clock is a clock-enable pulse (`tick_en`) on the system clock, and every cycle with `tick_en` high counts as one input clock. The divisor is an integer from 1 to 128, selected by a 7-bit code. The block produces a main divided output and a companion output, which is the same waveform delayed by 0 to 3 input clocks. The companion can also be inverted or switched off.

Control values reach the block already decoded and may change at any time. The delay, inversion and gating act on the companion output at once. A new divisor takes effect only at a period boundary, so the main output never produces a shortened pulse. A `running` flag reports that input clocks have arrived since reset.

Top module: `pcd_divider`

## Requirements
- R1: A divisor code of 0 selects a period of 128 input clocks. A code from 1 to 127 selects a period of that many input clocks.
- R2: While reset is asserted and after it is released, the active divisor is 32 and the count is at the start of a period. `div_out` is therefore high, and the delayed samples read low until input clocks have shifted real values in.
- R3: For a divisor N of 2 or more, `div_out` is high during the first floor(N/2) input clocks of each N-clock period and low for the rest. It does not change in cycles with `tick_en` low.
- R4: With divisor 1, `div_out` equals `tick_en` in every cycle.
- R5: A change of `div_code` takes effect only after the last input clock of the current period.
- R6: `phase_out` repeats the level that `div_out` had `shift_sel` input clocks earlier, with `shift_sel` from 0 to 3. A change of `shift_sel` takes effect in the same cycle.
- R7: When `phase_flip` is 1 and the divisor is 2 or more, `phase_out` is the inverse of the delayed level.
- R8: With divisor 1, `phase_flip` and `shift_sel` have no effect, and `phase_out` equals `div_out`.
- R9: When `phase_en` is 0, `phase_out` is 0.
- R10: `running` is 0 under reset. It becomes 1 after the first input clock following reset and then stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One fast input clock when high |
| div_code | input | 7 | Divisor code (0 = 128) |
| shift_sel | input | 2 | Delay of the companion output, in input clocks |
| phase_flip | input | 1 | Invert the companion output |
| phase_en | input | 1 | Enable the companion output |
| div_out | output | 1 | Main divided output |
| phase_out | output | 1 | Delayed, optionally inverted companion output |
| running | output | 1 | Input clocks seen since reset |

## Verification
Two actions can fall in one cycle: a divisor reload at a period boundary, and a live change of the companion delay or a switch into divide-by-1. The bench provokes this by changing `div_code` and `shift_sel` together on many different cycles, some of them exactly on the last input clock of a period. A scoreboard model, built from the requirements, predicts the boundary, the new period and the delayed level for each cycle. Each prediction is compared with the outputs in the middle of that cycle.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int PCD_SHIFT_W = 2;
  localparam int PCD_TAPS    = (1 << PCD_SHIFT_W) - 1;

  typedef struct packed {
    logic                   en;
    logic                   flip;
    logic [PCD_SHIFT_W-1:0] shift;
  } phase_ctl_t;
endpackage

// File: rtl/pcd_period_ctr.sv
module pcd_period_ctr #(
  parameter int CODE_W    = 7,
  parameter int RESET_DIV = 32,
  localparam int DIV_W    = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic [DIV_W-1:0]  div_q,
  output logic              main_lvl
);
  localparam logic [DIV_W-1:0] MAX_DIV = DIV_W'(1 << CODE_W);
  localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] next_div;
  logic [DIV_W-1:0] half;
  logic             last;

  // code zero stands for the largest divisor
  assign next_div = (code == '0) ? MAX_DIV : {1'b0, code};
  assign last     = (cnt == div_q - ONE);
  assign half     = div_q >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(RESET_DIV);
      cnt   <= '0;
    end else if (tick) begin
      if (last) begin
        cnt   <= '0;
        div_q <= next_div;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  assign main_lvl = (div_q == ONE) ? tick : (cnt < half);
endmodule

// File: rtl/pcd_phase_tap.sv
module pcd_phase_tap
  import pcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       main_lvl,
  input  logic       single,
  input  phase_ctl_t ctl,
  output logic       phase_lvl
);
  logic [PCD_TAPS-1:0]   hist;
  logic [PCD_TAPS:0]     taps;
  logic [PCD_SHIFT_W-1:0] eff_shift;
  logic                  raw;

  // stage 0 holds the level of the previous input clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist[0] <= 1'b0;
    else if (tick)  hist[0] <= main_lvl;
  end

  for (genvar g = 1; g < PCD_TAPS; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hist[g] <= 1'b0;
      else if (tick) hist[g] <= hist[g-1];
    end
  end

  assign taps      = {hist, main_lvl};
  assign eff_shift = single ? '0 : ctl.shift;
  assign raw       = taps[eff_shift];

  always_comb begin
    if (!ctl.en)     phase_lvl = 1'b0;
    else if (single) phase_lvl = main_lvl;
    else             phase_lvl = raw ^ ctl.flip;
  end
endmodule

// File: rtl/pcd_run_detect.sv
module pcd_run_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic running
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    running <= 1'b0;
    else if (tick) running <= 1'b1;
  end
endmodule

// File: rtl/pcd_divider.sv
module pcd_divider
  import pcd_pkg::*;
#(
  parameter int CODE_W    = 7,
  parameter int RESET_DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] div_code,
  input  logic [1:0]        shift_sel,
  input  logic              phase_flip,
  input  logic              phase_en,
  output logic              div_out,
  output logic              phase_out,
  output logic              running
);
  localparam int DIV_W = CODE_W + 1;

  logic [DIV_W-1:0] div_q;
  logic             main_lvl;
  logic             single;
  phase_ctl_t       ctl;

  assign ctl    = '{en: phase_en, flip: phase_flip, shift: shift_sel};
  assign single = (div_q == DIV_W'(1));

  pcd_period_ctr #(.CODE_W(CODE_W), .RESET_DIV(RESET_DIV)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .code(div_code),
    .div_q(div_q), .main_lvl(main_lvl)
  );

  pcd_phase_tap u_tap (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .main_lvl(main_lvl),
    .single(single), .ctl(ctl), .phase_lvl(phase_out)
  );

  pcd_run_detect u_run (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .running(running)
  );

  assign div_out = main_lvl;
endmodule

// File: rtl/pcd_divider_chk.sv
module pcd_divider_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [1:0]       shift_sel,
  input logic             phase_flip,
  input logic             phase_en,
  input logic [DIV_W-1:0] div_q,
  input logic             div_out,
  input logic             phase_out,
  input logic             running
);
  p_div_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= DIV_W'(1)) && (div_q <= DIV_W'(1 << (DIV_W-1))));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && div_q != DIV_W'(1)) |=> $stable(div_out));

  p_follow_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == DIV_W'(1)) |-> (div_out == tick_en));

  p_load_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(div_q));

  p_zero_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_sel == 2'd0 && phase_en && div_q != DIV_W'(1)) |-> (phase_out == (div_out ^ phase_flip)));

  p_single_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == DIV_W'(1) && phase_en) |-> (phase_out == div_out));

  p_gated_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_en |-> !phase_out);

  p_run_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
endmodule

bind pcd_divider pcd_divider_chk #(.DIV_W(CODE_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .shift_sel(shift_sel),
  .phase_flip(phase_flip), .phase_en(phase_en), .div_q(div_q),
  .div_out(div_out), .phase_out(phase_out), .running(running)
);

// File: tb/pcd_divider_bench.sv
module pcd_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [6:0] div_code = 7'd32;
  logic [1:0] shift_sel = 2'd0;
  logic       phase_flip = 1'b0;
  logic       phase_en = 1'b1;
  logic       div_out, phase_out, running;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    bit    d;
    bit    p;
    bit    r;
    string tag;
  } exp_t;
  exp_t sb[$];

  // requirement-level model state
  int m_n = 32, m_cnt = 0;
  bit m_h0 = 0, m_h1 = 0, m_h2 = 0, m_run = 0;

  always #2 clk = ~clk;

  pcd_divider u_pcd_divider (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_code(div_code),
    .shift_sel(shift_sel), .phase_flip(phase_flip), .phase_en(phase_en),
    .div_out(div_out), .phase_out(phase_out), .running(running)
  );

  task automatic drive(input bit te, input int code, input int sh,
                       input bit fl, input bit en, input bit rs, input string tag);
    exp_t e;
    bit main, raw, delayed;
    int eff;
    @(negedge clk);
    tick_en = te; div_code = 7'(code); shift_sel = 2'(sh);
    phase_flip = fl; phase_en = en; rst_n = rs;
    if (!rs) begin
      m_n = 32; m_cnt = 0; m_h0 = 0; m_h1 = 0; m_h2 = 0; m_run = 0;
    end
    main = (m_n == 1) ? te : (m_cnt < m_n / 2);
    eff = (m_n == 1) ? 0 : sh;
    delayed = (eff == 0) ? main : (eff == 1) ? m_h0 : (eff == 2) ? m_h1 : m_h2;
    raw = (m_n == 1) ? main : (delayed ^ fl);
    e.d = main; e.p = en ? raw : 1'b0; e.r = m_run; e.tag = tag;
    sb.push_back(e);
    if (rs && te) begin
      m_h2 = m_h1; m_h1 = m_h0; m_h0 = main; m_run = 1;
      if (m_cnt == m_n - 1) begin
        m_cnt = 0; m_n = (code == 0) ? 128 : code;
      end else m_cnt++;
    end
  endtask

  task automatic run(input int n, input int gap, input int code, input int sh,
                     input bit fl, input bit en, input string tag);
    for (int i = 0; i < n; i++)
      drive((gap == 0) || (i % (gap + 1) == 0), code, sh, fl, en, 1'b1, tag);
  endtask

  // monitor: compare mid-cycle, away from both edges
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (div_out !== e.d || phase_out !== e.p || running !== e.r) begin
          errors++;
          $display("FAIL %s: got div=%b phase=%b run=%b expected div=%b phase=%b run=%b",
                   e.tag, div_out, phase_out, running, e.d, e.p, e.r);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2 reset state, R10 running low in reset
    for (int i = 0; i < 4; i++) drive(1'b1, 5, 1, 1'b0, 1'b1, 1'b0, "R2/R10 reset");
    drive(1'b0, 5, 1, 1'b0, 1'b1, 1'b1, "R2 idle after reset");
    drive(1'b1, 5, 1, 1'b0, 1'b1, 1'b1, "R10 first tick");
    // R5 code 5 waits for the end of the 32-clock period
    run(40, 0, 5, 0, 1'b0, 1'b1, "R5 reload at boundary");
    // R3 odd divisor, dense and sparse input clocks
    run(30, 0, 5, 0, 1'b0, 1'b1, "R3 divide 5");
    run(45, 2, 5, 0, 1'b0, 1'b1, "R3 sparse ticks");
    run(30, 0, 6, 0, 1'b0, 1'b1, "R3 divide 6");
    // R1 code 0 and another odd code
    run(300, 0, 0, 0, 1'b0, 1'b1, "R1 code 0 = 128");
    run(140, 0, 7, 0, 1'b0, 1'b1, "R1 code 7");
    run(60, 0, 6, 0, 1'b0, 1'b1, "R1 code 6");
    // R6 live shift changes
    for (int s = 0; s < 4; s++) run(17, 0, 6, s, 1'b0, 1'b1, "R6 shift");
    run(20, 1, 6, 3, 1'b0, 1'b1, "R6 shift 3 sparse");
    // R7 inversion
    for (int s = 0; s < 4; s++) run(13, 0, 6, s, 1'b1, 1'b1, "R7 flip");
    // R4/R8 divide by 1 with shift and flip set
    run(20, 0, 1, 3, 1'b1, 1'b1, "R4 enter divide 1");
    run(24, 1, 1, 2, 1'b1, 1'b1, "R4/R8 divide 1 sparse");
    run(12, 0, 1, 1, 1'b0, 1'b1, "R8 divide 1 no flip");
    // R9 gated output
    run(20, 0, 4, 2, 1'b1, 1'b0, "R9 disabled");
    run(20, 0, 4, 2, 1'b0, 1'b0, "R9 disabled no flip");
    // R5 with R6: code and shift change together on many cycles
    for (int k = 0; k < 24; k++)
      run(k % 7 + 1, 0, (k % 3 == 0) ? 1 : 3 + k % 4, k % 4, k[0], 1'b1, "R5/R6 same cycle");
    run(30, 0, 9, 2, 1'b0, 1'b1, "R5/R6 settle");
    // R2 reset again mid-run, then R10
    drive(1'b1, 9, 2, 1'b0, 1'b1, 1'b0, "R2 reset again");
    run(40, 0, 9, 2, 1'b0, 1'b1, "R10 restart");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule